// File: doc/BRIEF.md
# Scan-list acquisition sequencer

This block runs the acquisition side of a multichannel sampling front end. Software writes channel descriptors one byte at a time into a scan-list queue. Four 16-bit words make one descriptor. A transfer engine moves the descriptor words into a four-word configuration stage. A programmable pacer decides when a conversion is started from a full configuration stage. Each conversion result that comes back from the converter is queued in a results queue, and the consumer drains that queue as a stream.

A single 16-bit command register controls the block. Some command codes are matched as whole values (scan go/halt, pacer on/off). Small values with bits 15:3 clear act as a mask of queue and stage clears. A status word reports occupancy, sequencing, converter activity and two sticky error flags.

The byte input and the result output are valid/ready streams. A byte moves on a clock edge where `sl_valid` and `sl_ready` are both high. `sl_ready` is low only while the scan-list queue is full. A result is removed on an edge where `res_valid` and `res_ready` are both high. The block never drops a byte that was offered, and it holds `res_data` steady until the consumer takes it.

Top module: `acq_scan_seq`

## Requirements
- R1: After reset, status reads 0x0020 (only the scan-list-empty bit, bit 5, is set), `sl_ready` is 1, and `res_valid` and `conv_start` are 0.
- R2: The scan-list queue holds SL_DEPTH words. `sl_ready` is 1 exactly while fewer than SL_DEPTH words are queued. Two accepted bytes form one word, and the first byte becomes bits 7:0. Status bit 5 is set exactly while the queue holds no complete word.
- R3: Writing command 0x0011 sets scanning (status bit 3), and writing 0x0010 clears it. While scanning, one queued word per cycle moves into the configuration stage until the stage holds four words.
- R4: Status bit 4 is set exactly while the configuration stage holds four words. Stage word k, in load order, appears on `cfg_entry` bits 16k+15:16k.
- R5: If bit 2 of an entry's second word is set, scanning clears when that entry's conversion completes. If that bit is clear, scanning continues.
- R6: Command 0x0031 enables the pacer and 0x0030 disables it. Divider D = {high[15:0], low[31:0]}. An enabled pacer ticks once every max(D,1) cycles. A tick with a full stage and an idle converter pulses `conv_start` for one cycle. Status bit 6 (converter busy) is then set from the next cycle until `adc_done` is seen.
- R7: A pacer tick while the converter is busy sets sticky status bit 8, and no conversion is issued for that tick. Bit 8 clears only when 0x0031 is written.
- R8: On `adc_done` while busy, `adc_data` is queued as a result and the configuration stage empties. Status bit 1 shows that at least one result is queued, and bit 0 shows that more than one is queued. Results come out in conversion order.
- R9: A result that completes while RES_DEPTH results are queued is discarded and sets sticky status bit 2. Bit 2 clears only through the results-queue clear.
- R10: A command write with bits 15:3 zero clears selected parts. Bit 2 clears the scan-list queue and any half-received word. Bit 1 clears the results queue and status bit 2. Bit 0 clears the configuration stage. The bits can be combined in one write.
- R11: Clearing the configuration stage also abandons a conversion in progress (bit 6 clears). An `adc_done` while not busy queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Command register write strobe |
| ctrl_wdata | input | 16 | Command value |
| div_lo_we | input | 1 | Write low pacer divider |
| div_hi_we | input | 1 | Write high pacer divider (bits 15:0 used) |
| div_wdata | input | 32 | Divider write data |
| sl_valid | input | 1 | Scan-list byte valid |
| sl_ready | output | 1 | Scan-list byte accepted when high |
| sl_byte | input | 8 | Scan-list byte |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes result |
| res_data | output | 16 | Oldest queued result |
| conv_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Converter finished |
| adc_data | input | 16 | Converter result |
| cfg_entry | output | 64 | Configuration stage words |
| status | output | 16 | Status word |

## Verification
The hardest states to reach from the ports are the two overrun flags. A pacer overrun needs converter latency longer than the pacer period. A results overrun needs more conversions than the results queue can hold while the consumer holds off. The bench has a converter responder whose latency can be programmed. It keeps `res_ready` low while it streams about twenty descriptors through the byte interface. The pacer divider is kept short in both cases. Abandoning a conversion is reached by clearing the stage during a long conversion and letting the late `adc_done` arrive.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  localparam logic [15:0] CMD_SCAN_GO   = 16'h0011;
  localparam logic [15:0] CMD_SCAN_HALT = 16'h0010;
  localparam logic [15:0] CMD_PACE_ON   = 16'h0031;
  localparam logic [15:0] CMD_PACE_OFF  = 16'h0030;

  localparam int ST_RES_MULTI = 0;
  localparam int ST_RES_ANY   = 1;
  localparam int ST_RES_OVR   = 2;
  localparam int ST_SCANNING  = 3;
  localparam int ST_PIPE_FULL = 4;
  localparam int ST_SL_EMPTY  = 5;
  localparam int ST_ADC_BUSY  = 6;
  localparam int ST_PACE_OVR  = 8;

  typedef struct packed {
    logic go;
    logic halt;
    logic pace_on;
    logic pace_off;
    logic clr_sl;
    logic clr_res;
    logic clr_pipe;
  } ctrl_cmd_t;

  function automatic ctrl_cmd_t decode_ctrl(input logic we, input logic [15:0] v);
    ctrl_cmd_t c;
    logic      mask_form;
    mask_form  = we && (v[15:3] == '0);
    c.go       = we && (v == CMD_SCAN_GO);
    c.halt     = we && (v == CMD_SCAN_HALT);
    c.pace_on  = we && (v == CMD_PACE_ON);
    c.pace_off = we && (v == CMD_PACE_OFF);
    c.clr_sl   = mask_form && v[2];
    c.clr_res  = mask_form && v[1];
    c.clr_pipe = mask_form && v[0];
    return c;
  endfunction

endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R2 / R9: a push into a full queue leaves the occupancy unchanged
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && count == $past(count)));

  // R8: popping an empty queue never wraps the occupancy
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);

endmodule

// File: rtl/acq_word_pack.sv
module acq_word_pack #(
  parameter int BYTE_W  = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_ok,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_ok,
  output logic [WORD_W-1:0] word
);

  logic              have_low;
  logic [BYTE_W-1:0] low_q;

  assign word_ok = byte_ok && have_low && !clr;
  assign word    = {byte_in, low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_low <= 1'b0;
      low_q    <= '0;
    end else if (clr) begin
      have_low <= 1'b0;
    end else if (byte_ok) begin
      if (!have_low) low_q <= byte_in;
      have_low <= !have_low;
    end
  end

  // R2: a word is only emitted on the second byte of a pair
  a_r2_pair_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !clr && !have_low) |=> have_low);

endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int LO_W  = 32,
  parameter int HI_W  = 16,
  localparam int DW   = LO_W + HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] divisor,
  output logic          tick
);

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  assign lim  = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick = en && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R6: with a divisor above one, ticks never come on consecutive cycles
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DW'(1) && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/acq_cfg_pipe.sv
module acq_cfg_pipe #(
  parameter int W        = 16,
  parameter int WORDS    = 4,
  parameter int LAST_IDX = 1,
  parameter int LAST_BIT = 2,
  localparam int IW      = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW      = $clog2(WORDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load,
  input  logic [W-1:0]   din,
  input  logic           release_i,
  output logic           full,
  output logic           last,
  output logic [CW-1:0]  fill,
  output logic [W*WORDS-1:0] entry
);

  logic [W-1:0] words [WORDS];

  assign full = (fill == CW'(WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      last <= 1'b0;
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (clr || release_i) begin
      fill <= '0;
    end else if (load && !full) begin
      words[fill[IW-1:0]] <= din;
      if (fill == CW'(LAST_IDX)) last <= din[LAST_BIT];
      fill <= fill + 1'b1;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign entry[g*W +: W] = words[g];
  end

  // R4: each accepted word adds exactly one to the stage fill
  a_r4_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !full && !clr && !release_i) |=> (fill == $past(fill) + 1'b1));

endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
  import acq_seq_pkg::*;
#(
  parameter int SL_DEPTH  = 16,
  parameter int RES_DEPTH = 16,
  parameter int DIV_LO_W  = 32,
  parameter int DIV_HI_W  = 16,
  localparam int WORD_W   = 16,
  localparam int ENTRY_W  = 4,
  localparam int SCW      = $clog2(SL_DEPTH + 1),
  localparam int RCW      = $clog2(RES_DEPTH + 1),
  localparam int PCW      = $clog2(ENTRY_W + 1),
  localparam int DIV_W    = DIV_LO_W + DIV_HI_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_we,
  input  logic [15:0]               ctrl_wdata,
  input  logic                      div_lo_we,
  input  logic                      div_hi_we,
  input  logic [31:0]               div_wdata,
  input  logic                      sl_valid,
  output logic                      sl_ready,
  input  logic [7:0]                sl_byte,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [15:0]               res_data,
  output logic                      conv_start,
  input  logic                      adc_done,
  input  logic [15:0]               adc_data,
  output logic [WORD_W*ENTRY_W-1:0] cfg_entry,
  output logic [15:0]               status
);

  ctrl_cmd_t cmd;
  assign cmd = decode_ctrl(ctrl_we, ctrl_wdata);

  logic scan_run, pace_en, adc_busy, pace_ovr, res_ovr;
  logic [DIV_LO_W-1:0] div_lo;
  logic [DIV_HI_W-1:0] div_hi;

  // byte stream into words
  logic              word_ok;
  logic [WORD_W-1:0] word;
  acq_word_pack #(.BYTE_W(8)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clr_sl),
    .byte_ok(sl_valid && sl_ready), .byte_in(sl_byte),
    .word_ok(word_ok), .word(word));

  // scan-list queue
  logic              sl_full, sl_empty, sl_pop;
  logic [WORD_W-1:0] sl_head;
  logic [SCW-1:0]    sl_count;
  acq_fifo #(.W(WORD_W), .DEPTH(SL_DEPTH)) u_slq (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clr_sl),
    .push(word_ok), .din(word), .pop(sl_pop),
    .dout(sl_head), .count(sl_count), .full(sl_full), .empty(sl_empty));

  assign sl_ready = !sl_full;

  // configuration stage
  logic           pipe_full, pipe_last, conv_done;
  logic [PCW-1:0] pipe_fill;
  assign sl_pop = scan_run && !sl_empty && !pipe_full && !cmd.clr_sl && !cmd.clr_pipe;

  acq_cfg_pipe #(.W(WORD_W), .WORDS(ENTRY_W), .LAST_IDX(1), .LAST_BIT(2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clr_pipe),
    .load(sl_pop), .din(sl_head), .release_i(conv_done),
    .full(pipe_full), .last(pipe_last), .fill(pipe_fill), .entry(cfg_entry));

  // pacer
  logic pace_tick;
  acq_pacer #(.LO_W(DIV_LO_W), .HI_W(DIV_HI_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(pace_en),
    .divisor({div_hi, div_lo}), .tick(pace_tick));

  assign conv_start = pace_tick && !adc_busy && pipe_full;
  assign conv_done  = adc_busy && adc_done;

  // results queue
  logic           res_full, res_empty;
  logic [RCW-1:0] res_count;
  acq_fifo #(.W(WORD_W), .DEPTH(RES_DEPTH)) u_resq (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clr_res),
    .push(conv_done), .din(adc_data), .pop(res_ready),
    .dout(res_data), .count(res_count), .full(res_full), .empty(res_empty));

  assign res_valid = !res_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_run <= 1'b0;
      pace_en  <= 1'b0;
      adc_busy <= 1'b0;
      pace_ovr <= 1'b0;
      res_ovr  <= 1'b0;
      div_lo   <= '0;
      div_hi   <= '0;
    end else begin
      if (cmd.go)                          scan_run <= 1'b1;
      else if (cmd.halt)                   scan_run <= 1'b0;
      else if (conv_done && pipe_last)     scan_run <= 1'b0;

      if (cmd.pace_on)                     pace_en <= 1'b1;
      else if (cmd.pace_off)               pace_en <= 1'b0;

      if (cmd.clr_pipe)                    adc_busy <= 1'b0;
      else if (conv_start)                 adc_busy <= 1'b1;
      else if (conv_done)                  adc_busy <= 1'b0;

      if (cmd.pace_on)                     pace_ovr <= 1'b0;
      else if (pace_tick && adc_busy)      pace_ovr <= 1'b1;

      if (cmd.clr_res)                     res_ovr <= 1'b0;
      else if (conv_done && res_full)      res_ovr <= 1'b1;

      if (div_lo_we) div_lo <= div_wdata[DIV_LO_W-1:0];
      if (div_hi_we) div_hi <= div_wdata[DIV_HI_W-1:0];
    end
  end

  always_comb begin
    status               = '0;
    status[ST_RES_MULTI] = (res_count > RCW'(1));
    status[ST_RES_ANY]   = !res_empty;
    status[ST_RES_OVR]   = res_ovr;
    status[ST_SCANNING]  = scan_run;
    status[ST_PIPE_FULL] = pipe_full;
    status[ST_SL_EMPTY]  = sl_empty;
    status[ST_ADC_BUSY]  = adc_busy;
    status[ST_PACE_OVR]  = pace_ovr;
  end

  // R6: an issued conversion makes the converter busy on the next cycle
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !cmd.clr_pipe) |=> status[ST_ADC_BUSY]);

  // R5: completing a last-marked entry suspends scanning
  a_r5_suspend_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && pipe_last && !cmd.go) |=> !status[ST_SCANNING]);

  // R7: a tick during a conversion raises the pacer overrun flag
  a_r7_pace_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_tick && adc_busy && !cmd.pace_on) |=> status[ST_PACE_OVR]);

  // R9: the results overrun flag is sticky until the results clear
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ovr && !cmd.clr_res) |=> status[ST_RES_OVR]);

  // R11: a stage clear abandons the conversion and empties the stage
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr_pipe |=> (!status[ST_ADC_BUSY] && !status[ST_PIPE_FULL]));

  // R2: the empty flag agrees with the queue occupancy
  a_r2_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_count == '0) |-> status[ST_SL_EMPTY]);

  // R4: the stage never holds more than one entry
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_fill <= PCW'(ENTRY_W));

endmodule

// File: tb/test_acq_scan_seq.sv
module test_acq_scan_seq;

  localparam int SL_DEPTH  = 16;
  localparam int RES_DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        div_lo_we = 1'b0, div_hi_we = 1'b0;
  logic [31:0] div_wdata = '0;
  logic        sl_valid = 1'b0;
  logic        sl_ready;
  logic [7:0]  sl_byte = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_data;
  logic        conv_start;
  logic        adc_done;
  logic [15:0] adc_data;
  logic [63:0] cfg_entry;
  logic [15:0] status;

  always #10 clk = ~clk;

  acq_scan_seq #(.SL_DEPTH(SL_DEPTH), .RES_DEPTH(RES_DEPTH)) i_acq_scan_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .div_lo_we(div_lo_we), .div_hi_we(div_hi_we), .div_wdata(div_wdata),
    .sl_valid(sl_valid), .sl_ready(sl_ready), .sl_byte(sl_byte),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .conv_start(conv_start), .adc_done(adc_done), .adc_data(adc_data),
    .cfg_entry(cfg_entry), .status(status));

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [15:0] m_slq[$];
  bit [15:0] m_resq[$];
  bit [15:0] m_pw[4];
  int        m_fill;
  bit        m_last, m_run, m_pen, m_busy, m_ovr, m_pov, m_phase;
  bit [7:0]  m_lo;
  bit [31:0] m_dlo;
  bit [15:0] m_dhi;
  longint unsigned m_pcnt;

  function automatic bit m_tick();
    longint unsigned d, lim;
    d = {m_dhi, m_dlo};
    lim = (d == 0) ? 0 : d - 1;
    return m_pen && (m_pcnt >= lim);
  endfunction

  function automatic logic [15:0] m_status();
    logic [15:0] s = '0;
    s[0] = m_resq.size() > 1;
    s[1] = m_resq.size() > 0;
    s[2] = m_ovr;
    s[3] = m_run;
    s[4] = (m_fill == 4);
    s[5] = (m_slq.size() == 0);
    s[6] = m_busy;
    s[8] = m_pov;
    return s;
  endfunction

  always @(posedge clk) begin : model
    bit go, halt, pon, poff, csl, cres, cpipe, tk, start, done, spop, acc, mask;
    bit [15:0] head;
    if (!rst_n) begin
      m_slq.delete(); m_resq.delete();
      for (int i = 0; i < 4; i++) m_pw[i] = '0;
      m_fill = 0; m_last = 0; m_run = 0; m_pen = 0; m_busy = 0; m_ovr = 0; m_pov = 0;
      m_phase = 0; m_lo = 0; m_dlo = 0; m_dhi = 0; m_pcnt = 0;
    end else begin
      mask  = ctrl_we && (ctrl_wdata[15:3] == 0);
      go    = ctrl_we && ctrl_wdata == 16'h0011;
      halt  = ctrl_we && ctrl_wdata == 16'h0010;
      pon   = ctrl_we && ctrl_wdata == 16'h0031;
      poff  = ctrl_we && ctrl_wdata == 16'h0030;
      csl   = mask && ctrl_wdata[2];
      cres  = mask && ctrl_wdata[1];
      cpipe = mask && ctrl_wdata[0];
      tk    = m_tick();
      start = tk && !m_busy && (m_fill == 4);
      done  = m_busy && adc_done;
      spop  = m_run && m_slq.size() > 0 && m_fill < 4 && !csl && !cpipe;
      acc   = sl_valid && (m_slq.size() < SL_DEPTH);
      head  = (m_slq.size() > 0) ? m_slq[0] : 16'h0;
      // results
      if (cres) begin
        m_resq.delete(); m_ovr = 0;
      end else begin
        if (res_ready && m_resq.size() > 0) void'(m_resq.pop_front());
        if (done) begin
          if (m_resq.size() + ((res_ready && m_resq.size() > 0) ? 1 : 0) >= RES_DEPTH) m_ovr = 1;
          else m_resq.push_back(adc_data);
        end
      end
      // scanning
      if (go) m_run = 1;
      else if (halt) m_run = 0;
      else if (done && m_last) m_run = 0;
      // stage
      if (cpipe || done) m_fill = 0;
      else if (spop) begin
        m_pw[m_fill] = head;
        if (m_fill == 1) m_last = head[2];
        m_fill++;
      end
      // scan-list queue and byte pairing
      if (csl) begin
        m_slq.delete(); m_phase = 0;
      end else begin
        if (spop) void'(m_slq.pop_front());
        if (acc) begin
          if (!m_phase) m_lo = sl_byte;
          else m_slq.push_back({sl_byte, m_lo});
          m_phase = !m_phase;
        end
      end
      // converter / pacer
      if (pon) m_pov = 0;
      else if (tk && m_busy) m_pov = 1;
      if (cpipe) m_busy = 0;
      else if (start) m_busy = 1;
      else if (done) m_busy = 0;
      if (!m_pen || tk) m_pcnt = 0; else m_pcnt++;
      if (pon) m_pen = 1; else if (poff) m_pen = 0;
      if (div_lo_we) m_dlo = div_wdata;
      if (div_hi_we) m_dhi = div_wdata[15:0];
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sl_ready !== (m_slq.size() < SL_DEPTH)) begin
        failures++; $display("FAIL R2 sl_ready act=%0b exp=%0b", sl_ready, m_slq.size() < SL_DEPTH);
      end
      if (res_valid !== (m_resq.size() > 0)) begin
        failures++; $display("FAIL R8 res_valid act=%0b exp=%0b", res_valid, m_resq.size() > 0);
      end else if (res_valid && res_data !== m_resq[0]) begin
        failures++; $display("FAIL R8 res_data act=%0h exp=%0h", res_data, m_resq[0]);
      end
      if (conv_start !== (m_tick() && !m_busy && m_fill == 4)) begin
        failures++; $display("FAIL R6 conv_start act=%0b exp=%0b", conv_start, m_tick() && !m_busy && m_fill == 4);
      end
      if (status !== m_status()) begin
        failures++; $display("FAIL R3 status act=%0h exp=%0h", status, m_status());
      end
      if (cfg_entry !== {m_pw[3], m_pw[2], m_pw[1], m_pw[0]}) begin
        failures++; $display("FAIL R4 cfg_entry act=%0h exp=%0h", cfg_entry, {m_pw[3], m_pw[2], m_pw[1], m_pw[0]});
      end
    end
  end

  // ---------------- converter responder ----------------
  int        adc_lat = 3;
  bit        stray_req = 0;
  bit [15:0] seq = 16'h1000;

  initial begin
    adc_done = 1'b0;
    adc_data = '0;
    forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (stray_req) begin
        stray_req = 0;
        adc_done  = 1'b1;
        adc_data  = 16'hDEAD;
      end else if (conv_start) begin
        @(negedge clk);
        repeat (adc_lat - 1) @(negedge clk);
        adc_done = 1'b1;
        adc_data = seq;
        seq++;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus tasks (start and end at a negedge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_div(input logic [31:0] lo, input logic [15:0] hi);
    div_lo_we = 1'b1; div_wdata = lo;
    @(negedge clk);
    div_lo_we = 1'b0; div_hi_we = 1'b1; div_wdata = {16'h0, hi};
    @(negedge clk);
    div_hi_we = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    sl_valid = 1'b1; sl_byte = b;
    while (!sl_ready) @(negedge clk);
    @(negedge clk);
    sl_valid = 1'b0;
  endtask

  task automatic push_word(input logic [15:0] w);
    push_byte(w[7:0]);
    push_byte(w[15:8]);
  endtask

  task automatic push_entry(input logic [15:0] w0, w1, w2, w3);
    push_word(w0); push_word(w1); push_word(w2); push_word(w3);
  endtask

  task automatic wait_bit(input int b, input logic v);
    for (int n = 0; n < 3000 && status[b] !== v; n++) @(negedge clk);
  endtask

  task automatic pop_one();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "status", status, 16'h0020);
    chk("R1", "sl_ready", sl_ready, 1);
    chk("R1", "res_valid", res_valid, 0);
    chk("R1", "conv_start", conv_start, 0);

    // R3 go / halt with nothing queued
    wr_ctrl(16'h0011);
    chk("R3", "scanning after go", status[3], 1);
    wr_ctrl(16'h0010);
    chk("R3", "scanning after halt", status[3], 0);

    // R2 single byte leaves queue empty, pair fills one word
    push_byte(8'h34);
    chk("R2", "empty after one byte", status[5], 1);
    push_byte(8'h12);
    chk("R2", "not empty after pair", status[5], 0);
    // fill to depth
    for (int i = 1; i < SL_DEPTH; i++) push_word(16'h0100 + 16'(i));
    sl_valid = 1'b1; sl_byte = 8'hAA;
    chk("R2", "ready low when full", sl_ready, 0);
    sl_valid = 1'b0;
    // R10 scan-list clear
    wr_ctrl(16'h0004);
    chk("R10", "scan list empty after clear", status[5], 1);
    chk("R10", "ready after clear", sl_ready, 1);

    // R4 / R2 entry transfer and byte order
    wr_div(32'd5, 16'h0);
    push_entry(16'h0000, 16'h0004, 16'h08C0, 16'hC001);
    wr_ctrl(16'h0011);
    idle(6);
    chk("R4", "stage full", status[4], 1);
    chk("R4", "stage words", cfg_entry, 64'hC001_08C0_0004_0000);
    chk("R3", "scanning", status[3], 1);

    // R6 pacer timing: issue four cycles after enable
    wr_ctrl(16'h0031);
    idle(3);
    chk("R6", "no issue yet", conv_start, 0);
    idle(1);
    chk("R6", "issue on fifth", conv_start, 1);
    idle(1);
    chk("R6", "busy", status[6], 1);
    wait_bit(1, 1);
    chk("R8", "first result", res_data, 16'h1000);
    chk("R5", "suspended after last", status[3], 0);
    pop_one();
    chk("R8", "drained", res_valid, 0);

    // R5 / R8 two entries, only the second last-marked
    push_entry(16'h0001, 16'h0000, 16'h0040, 16'hC002);
    push_entry(16'h0002, 16'h0004, 16'h0080, 16'hC005);
    wr_ctrl(16'h0011);
    wait_bit(3, 0);
    idle(2);
    chk("R8", "more than one", status[0], 1);
    chk("R5", "both converted", res_data, 16'h1001);
    pop_one();
    chk("R8", "second in order", res_data, 16'h1002);
    pop_one();

    // R7 pacer overrun
    wr_ctrl(16'h0030);
    wr_div(32'd2, 16'h0);
    adc_lat = 12;
    push_entry(16'h0, 16'h0004, 16'h0, 16'h0);
    wr_ctrl(16'h0011);
    wr_ctrl(16'h0031);
    wait_bit(6, 1);
    idle(6);
    chk("R7", "pacer overrun set", status[8], 1);
    wait_bit(1, 1);
    chk("R7", "overrun sticky", status[8], 1);
    pop_one();
    wr_ctrl(16'h0031);
    chk("R7", "overrun cleared", status[8], 0);

    // R9 results overrun with consumer held off
    adc_lat = 1;
    wr_ctrl(16'h0011);
    for (int i = 0; i < 19; i++) push_entry(16'(i), 16'h0, 16'h0, 16'h0);
    push_entry(16'h0, 16'h0004, 16'h0, 16'h0);
    wait_bit(3, 0);
    idle(8);
    chk("R9", "results overrun", status[2], 1);
    chk("R9", "queue full", status[1:0], 2'b11);
    pop_one();
    chk("R9", "sticky after pop", status[2], 1);
    wr_ctrl(16'h0002);
    chk("R9", "cleared by results clear", status[2], 0);
    chk("R10", "results emptied", res_valid, 0);

    // R11 abandon a conversion
    adc_lat = 20;
    push_entry(16'h0, 16'h0004, 16'h0, 16'h0);
    wr_ctrl(16'h0011);
    wait_bit(6, 1);
    wr_ctrl(16'h0001);
    chk("R11", "busy cleared", status[6], 0);
    chk("R11", "stage cleared", status[4], 0);
    idle(25);
    chk("R11", "late done ignored", res_valid, 0);
    @(posedge clk); stray_req = 1; @(negedge clk);
    idle(3);
    chk("R11", "stray done ignored", res_valid, 0);
    wr_ctrl(16'h0010);

    // R10 combined clear
    push_byte(8'h55);
    push_word(16'h1234);
    wr_ctrl(16'h0007);
    chk("R10", "combined clear", status & 16'h0037, 16'h0020);
    push_byte(8'h78);
    push_byte(8'h56);
    wr_ctrl(16'h0011);
    idle(2);
    chk("R10", "half word discarded", cfg_entry[15:0], 16'h5678);
    wr_ctrl(16'h0010);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule